// File: doc/BRIEF.md
# Timer Input Capture Channel

This block timestamps events on one external pin. The pin passes through a two-stage synchronizer and then a programmable glitch filter. One edge direction is chosen, and an optional prescaler keeps only every 2nd, 4th or 8th of those edges. On a kept edge the block stores the value of an external free-running timer count in a capture register and raises a capture flag. The timer counter, the register bus and the DMA engine are outside the block. They connect through plain ports.

Reading the capture value acknowledges the flag. If a new capture lands while the flag is still pending, a sticky overcapture flag records it, and only an explicit clear removes it. The interrupt request is a level that follows the pending flag when it is enabled. The DMA request is a one-cycle pulse for each capture when it is enabled. Software can inject a capture event directly. That event bypasses the filter, the prescaler and the capture enable.

Top module: `icap_channel`

## Requirements
- R1: While `rst` is high at a clock edge, `cap_val` becomes 0 and `cap_flag`, `ovr_flag`, `irq` and `dma_req` become 0.
- R2: With filter code `f` on `cfg_filt`, the filtered input changes only after the synchronized input has differed from it for 2^f consecutive clock samples. Code 0 means no filtering and code 3 means 8 samples. A pulse shorter than this produces no capture. If the first clock edge that samples a new input level is counted as edge 0, the capture loads the `cnt_val` present at edge 2^f + 2.
- R3: With `cfg_pol` = 0 only rising edges of the filtered input are active. With `cfg_pol` = 1 only falling edges are active. The other direction never causes a capture.
- R4: `cfg_psc` codes 00, 01, 10 and 11 capture on every 1st, 2nd, 4th and 8th active edge respectively. After the enable has been low, the first capture comes on the Nth active edge.
- R5: While `cfg_en` is 0, active edges cause no capture and the prescaler count returns to zero.
- R6: A capture loads `cnt_val` into `cap_val` and sets `cap_flag` at the same clock edge.
- R7: A one-cycle `rd_cap` pulse clears `cap_flag` at the next edge. If a capture occurs in the same cycle, the capture wins and the flag stays set.
- R8: A capture while `cap_flag` is set and no `rd_cap` is pending sets `ovr_flag`. `ovr_flag` stays set through reads and is cleared only by `ovr_clr`.
- R9: `irq` is high exactly when `cap_flag` is set and `cfg_irq_en` was high at the edge that updated the flag.
- R10: With `cfg_dma_en` = 1, each capture makes `dma_req` high for the one cycle after the capture edge. With `cfg_dma_en` = 0, `dma_req` stays low.
- R11: `sw_evt` high at a clock edge captures `cnt_val` at that edge even when `cfg_en` is 0, bypassing the filter and the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CNT_W | Free-running timer count to be captured |
| sig_in | input | 1 | Asynchronous external input |
| cfg_en | input | 1 | Capture enable for the input path |
| cfg_pol | input | 1 | Edge select: 0 rising, 1 falling |
| cfg_psc | input | 2 | Edge prescaler code |
| cfg_filt | input | FILT_W | Filter code, 2^code samples |
| cfg_irq_en | input | 1 | Interrupt request enable |
| cfg_dma_en | input | 1 | DMA request enable |
| sw_evt | input | 1 | Software capture event |
| rd_cap | input | 1 | Capture register read strobe, clears the flag |
| ovr_clr | input | 1 | Overcapture flag clear strobe |
| cap_val | output | CNT_W | Captured timer value |
| cap_flag | output | 1 | Capture pending |
| ovr_flag | output | 1 | Overcapture happened |
| irq | output | 1 | Interrupt request level |
| dma_req | output | 1 | DMA request pulse |

## Verification
The timer count advances by one each cycle, so a wrong filter run length or a wrong synchronizer depth shows up as a `cap_val` off by a few counts at the first capture after the fault. A prescaler count that is out of step, or that is not cleared when the enable drops, shows up at the next few active edges as a missing or extra `dma_req` pulse. The scoreboard flags that pulse at once. A flag register that is stuck or cleared wrongly is visible on `cap_flag`, `ovr_flag` and `irq` one cycle after the read or clear strobe.

// File: rtl/icap_pkg.sv
package icap_pkg;
  typedef enum logic [1:0] {
    PSC_DIV1 = 2'b00,
    PSC_DIV2 = 2'b01,
    PSC_DIV4 = 2'b10,
    PSC_DIV8 = 2'b11
  } psc_e;

  localparam int PSC_CNT_W = 3;

  // last count value before a capture fires: divisor minus one
  function automatic logic [PSC_CNT_W-1:0] psc_last(input psc_e code);
    logic [PSC_CNT_W:0] div;
    div = ({{PSC_CNT_W{1'b0}}, 1'b1} << code);
    return PSC_CNT_W'(div - 1'b1);
  endfunction
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= 1'b0;
    else     stg[0] <= d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= 1'b0;
        else     stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FILT_W-1:0] code,
  input  logic              s_in,
  output logic              f_out
);
  localparam int RUN_W = (1 << FILT_W);

  logic [RUN_W:0] need;
  logic [RUN_W:0] run;
  logic           f_q;

  assign need = ({{RUN_W{1'b0}}, 1'b1} << code);

  always_ff @(posedge clk) begin
    if (rst) begin
      f_q <= 1'b0;
      run <= '0;
    end else if (s_in == f_q) begin
      run <= '0;
    end else if (run + 1'b1 == need) begin
      f_q <= s_in;
      run <= '0;
    end else begin
      run <= run + 1'b1;
    end
  end

  assign f_out = f_q;
endmodule

// File: rtl/icap_edge_psc.sv
module icap_edge_psc
  import icap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       f_in,
  input  logic       pol,
  input  logic       en,
  input  logic [1:0] psc,
  output logic       fire
);
  logic                 f_d;
  logic                 act_edge;
  logic                 qual;
  logic [PSC_CNT_W-1:0] pcnt;
  logic [PSC_CNT_W-1:0] last;

  assign act_edge = pol ? (f_d & ~f_in) : (f_in & ~f_d);
  assign qual     = act_edge & en;
  assign last     = psc_last(psc_e'(psc));
  assign fire     = qual & (pcnt >= last);

  always_ff @(posedge clk) begin
    if (rst) begin
      f_d  <= 1'b0;
      pcnt <= '0;
    end else begin
      f_d <= f_in;
      if (!en)        pcnt <= '0;
      else if (fire)  pcnt <= '0;
      else if (qual)  pcnt <= pcnt + 1'b1;
    end
  end
endmodule

// File: rtl/icap_latch.sv
module icap_latch #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             rd,
  input  logic             oclr,
  input  logic             irq_en,
  input  logic             dma_en,
  output logic [CNT_W-1:0] val_q,
  output logic             flag_q,
  output logic             ovr_q,
  output logic             irq_q,
  output logic             dma_q
);
  logic flag_n;

  always_comb begin
    if (evt)     flag_n = 1'b1;
    else if (rd) flag_n = 1'b0;
    else         flag_n = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q  <= '0;
      flag_q <= 1'b0;
      ovr_q  <= 1'b0;
      irq_q  <= 1'b0;
      dma_q  <= 1'b0;
    end else begin
      if (evt) val_q <= cnt_val;
      flag_q <= flag_n;
      if (evt && flag_q && !rd) ovr_q <= 1'b1;
      else if (oclr)            ovr_q <= 1'b0;
      irq_q <= irq_en & flag_n;
      dma_q <= dma_en & evt;
    end
  end
endmodule

// File: rtl/icap_channel.sv
module icap_channel #(
  parameter int CNT_W       = 16,
  parameter int FILT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              sig_in,
  input  logic              cfg_en,
  input  logic              cfg_pol,
  input  logic [1:0]        cfg_psc,
  input  logic [FILT_W-1:0] cfg_filt,
  input  logic              cfg_irq_en,
  input  logic              cfg_dma_en,
  input  logic              sw_evt,
  input  logic              rd_cap,
  input  logic              ovr_clr,
  output logic [CNT_W-1:0]  cap_val,
  output logic              cap_flag,
  output logic              ovr_flag,
  output logic              irq,
  output logic              dma_req
);
  logic s_sync;
  logic s_filt;
  logic hw_fire;
  logic cap_evt;

  icap_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d(sig_in), .q(s_sync)
  );

  icap_filter #(.FILT_W(FILT_W)) filt_i (
    .clk(clk), .rst(rst), .code(cfg_filt), .s_in(s_sync), .f_out(s_filt)
  );

  icap_edge_psc edge_i (
    .clk(clk), .rst(rst), .f_in(s_filt), .pol(cfg_pol), .en(cfg_en),
    .psc(cfg_psc), .fire(hw_fire)
  );

  assign cap_evt = hw_fire | sw_evt;

  icap_latch #(.CNT_W(CNT_W)) latch_i (
    .clk(clk), .rst(rst), .evt(cap_evt), .cnt_val(cnt_val), .rd(rd_cap),
    .oclr(ovr_clr), .irq_en(cfg_irq_en), .dma_en(cfg_dma_en),
    .val_q(cap_val), .flag_q(cap_flag), .ovr_q(ovr_flag), .irq_q(irq),
    .dma_q(dma_req)
  );
endmodule

// File: rtl/icap_channel_chk.sv
module icap_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt_val,
  input logic             cfg_en,
  input logic             cfg_irq_en,
  input logic             cfg_dma_en,
  input logic             sw_evt,
  input logic             rd_cap,
  input logic             ovr_clr,
  input logic [CNT_W-1:0] cap_val,
  input logic             cap_flag,
  input logic             ovr_flag,
  input logic             irq,
  input logic             dma_req
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!cap_flag && !ovr_flag && !irq && !dma_req && cap_val == '0));

  a_r5_disabled_hold: assert property (@(posedge clk) disable iff (rst)
    (!rst && !cfg_en && !sw_evt) |=> cap_val == $past(cap_val));

  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    (!rst && rd_cap && !sw_evt && !cfg_en) |=> !cap_flag);

  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    (!rst && ovr_flag && !ovr_clr) |=> ovr_flag);

  a_r9_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq == (cap_flag && $past(cfg_irq_en)));

  a_r10_dma_gate: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> ($past(cfg_dma_en) && cap_flag));

  a_r11_sw_capture: assert property (@(posedge clk) disable iff (rst)
    (!rst && sw_evt) |=> (cap_flag && cap_val == $past(cnt_val)));
endmodule

bind icap_channel icap_channel_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .cnt_val(cnt_val), .cfg_en(cfg_en),
  .cfg_irq_en(cfg_irq_en), .cfg_dma_en(cfg_dma_en), .sw_evt(sw_evt),
  .rd_cap(rd_cap), .ovr_clr(ovr_clr), .cap_val(cap_val),
  .cap_flag(cap_flag), .ovr_flag(ovr_flag), .irq(irq), .dma_req(dma_req)
);

// File: tb/icap_channel_tb_top.sv
module icap_channel_tb_top;
  localparam int CNT_W  = 16;
  localparam int FILT_W = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [CNT_W-1:0]  cnt_val = 16'h1234;
  logic              sig_in = 1'b0;
  logic              cfg_en = 1'b0;
  logic              cfg_pol = 1'b0;
  logic [1:0]        cfg_psc = 2'b00;
  logic [FILT_W-1:0] cfg_filt = '0;
  logic              cfg_irq_en = 1'b0;
  logic              cfg_dma_en = 1'b1;
  logic              sw_evt = 1'b0;
  logic              rd_cap = 1'b0;
  logic              ovr_clr = 1'b0;
  logic [CNT_W-1:0]  cap_val;
  logic              cap_flag, ovr_flag, irq, dma_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [CNT_W-1:0] exp_q[$];
  bit lvl = 1'b0;
  int pc = 0;

  always #2 clk = ~clk;

  icap_channel #(.CNT_W(CNT_W), .FILT_W(FILT_W)) dut_i (
    .clk(clk), .rst(rst), .cnt_val(cnt_val), .sig_in(sig_in),
    .cfg_en(cfg_en), .cfg_pol(cfg_pol), .cfg_psc(cfg_psc),
    .cfg_filt(cfg_filt), .cfg_irq_en(cfg_irq_en), .cfg_dma_en(cfg_dma_en),
    .sw_evt(sw_evt), .rd_cap(rd_cap), .ovr_clr(ovr_clr),
    .cap_val(cap_val), .cap_flag(cap_flag), .ovr_flag(ovr_flag),
    .irq(irq), .dma_req(dma_req)
  );

  // timer count model: advances at every falling clock edge
  initial forever begin
    @(negedge clk);
    cnt_val = cnt_val + 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: every DMA pulse must match the oldest expected capture
  initial forever begin
    @(negedge clk);
    if (!rst && dma_req) begin
      if (exp_q.size() == 0)
        chk(1'b0, "R3/R5 unexpected capture", 32'(cap_val), 32'hffffffff);
      else begin
        logic [CNT_W-1:0] e;
        e = exp_q.pop_front();
        chk(cap_val == e, "R2/R6 capture value", 32'(cap_val), 32'(e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  function automatic int divisor();
    return 1 << cfg_psc;
  endfunction

  // drive a settled level; predict whether a capture follows
  task automatic drive_level(input bit v);
    int n;
    bit act;
    n = 1 << cfg_filt;
    @(negedge clk); #1;
    act = (cfg_pol == 1'b0) ? (v && !lvl) : (!v && lvl);
    lvl = v;
    sig_in = v;
    if (act && cfg_en) begin
      pc++;
      if (pc == divisor()) begin
        pc = 0;
        exp_q.push_back(cnt_val + CNT_W'(n + 2));
      end
    end
    repeat (n + 6) @(posedge clk);
  endtask

  task automatic pulse_high();
    drive_level(1'b1);
    drive_level(1'b0);
  endtask

  task automatic strobe_rd();
    @(negedge clk); #1 rd_cap = 1'b1;
    @(negedge clk); #1 rd_cap = 1'b0;
  endtask

  task automatic set_en(input bit v);
    @(negedge clk); #1 cfg_en = v;
    if (!v) pc = 0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(cap_val == 0 && !cap_flag && !ovr_flag && !irq && !dma_req,
        "R1 reset state", {cap_flag, ovr_flag, irq, dma_req}, 0);
    rst = 1'b0;
    cfg_irq_en = 1'b1;
    set_en(1'b1);

    // R6 R9: rising edge, no filter
    drive_level(1'b1);
    chk(cap_flag == 1'b1, "R6 flag set", 32'(cap_flag), 1);
    chk(irq == 1'b1, "R9 irq follows flag", 32'(irq), 1);
    // R3: falling edge ignored with rising polarity
    drive_level(1'b0);
    strobe_rd();
    @(negedge clk);
    chk(cap_flag == 1'b0, "R7 read clears flag", 32'(cap_flag), 0);
    chk(irq == 1'b0, "R9 irq drops", 32'(irq), 0);

    // R3: falling polarity
    @(negedge clk); #1 cfg_pol = 1'b1;
    drive_level(1'b1);
    chk(cap_flag == 1'b0, "R3 rising ignored", 32'(cap_flag), 0);
    drive_level(1'b0);
    chk(cap_flag == 1'b1, "R3 falling captured", 32'(cap_flag), 1);
    strobe_rd();
    @(negedge clk); #1 cfg_pol = 1'b0;

    // R2: 8-sample filter, short glitch rejected
    @(negedge clk); #1 cfg_filt = 4'd3;
    @(negedge clk); #1 sig_in = 1'b1;
    repeat (5) @(negedge clk);
    #1 sig_in = 1'b0;
    repeat (16) @(posedge clk);
    @(negedge clk);
    chk(cap_flag == 1'b0, "R2 glitch rejected", 32'(cap_flag), 0);
    pulse_high();
    chk(cap_flag == 1'b1, "R2 filtered edge captured", 32'(cap_flag), 1);
    strobe_rd();
    @(negedge clk); #1 cfg_filt = '0;

    // R4: divide by 4 over 8 edges, read after each
    @(negedge clk); #1 cfg_psc = 2'b10;
    set_en(1'b0);
    set_en(1'b1);
    for (int i = 0; i < 8; i++) begin
      pulse_high();
      strobe_rd();
    end
    repeat (3) @(posedge clk);
    chk(exp_q.size() == 0, "R4 divide by 4", exp_q.size(), 0);

    // R5: disabled capture and prescaler clear (divide by 2)
    @(negedge clk); #1 cfg_psc = 2'b01;
    pulse_high();
    set_en(1'b0);
    pulse_high();
    @(negedge clk);
    chk(cap_flag == 1'b0, "R5 no capture while disabled", 32'(cap_flag), 0);
    set_en(1'b1);
    pulse_high();
    chk(cap_flag == 1'b0, "R5 prescaler count cleared", 32'(cap_flag), 0);
    pulse_high();
    chk(cap_flag == 1'b1, "R4 second edge captures", 32'(cap_flag), 1);
    strobe_rd();
    @(negedge clk); #1 cfg_psc = 2'b00;

    // R8: overcapture
    pulse_high();
    pulse_high();
    chk(ovr_flag == 1'b1, "R8 overcapture set", 32'(ovr_flag), 1);
    strobe_rd();
    @(negedge clk);
    chk(ovr_flag == 1'b1 && !cap_flag, "R8 read keeps ovr", {ovr_flag, cap_flag}, 2);
    @(negedge clk); #1 ovr_clr = 1'b1;
    @(negedge clk); #1 ovr_clr = 1'b0;
    @(negedge clk);
    chk(ovr_flag == 1'b0, "R8 explicit clear", 32'(ovr_flag), 0);

    // R11: software event with capture disabled
    set_en(1'b0);
    @(negedge clk); #1 sw_evt = 1'b1;
    exp_q.push_back(cnt_val);
    @(negedge clk); #1 sw_evt = 1'b0;
    @(negedge clk);
    chk(cap_flag == 1'b1, "R11 sw event sets flag", 32'(cap_flag), 1);

    // R7: read and capture in same cycle, capture wins, no overcapture
    @(negedge clk); #1 sw_evt = 1'b1; rd_cap = 1'b1;
    exp_q.push_back(cnt_val);
    @(negedge clk); #1 sw_evt = 1'b0; rd_cap = 1'b0;
    @(negedge clk);
    chk(cap_flag == 1'b1 && !ovr_flag, "R7 capture beats read",
        {cap_flag, ovr_flag}, 2);
    strobe_rd();

    // R10: DMA disabled, capture still happens
    @(negedge clk); #1 cfg_dma_en = 1'b0; cfg_irq_en = 1'b0;
    @(negedge clk); #1 sw_evt = 1'b1;
    begin
      logic [CNT_W-1:0] v;
      v = cnt_val;
      @(negedge clk); #1 sw_evt = 1'b0;
      chk(dma_req == 1'b0, "R10 dma gated off", 32'(dma_req), 0);
      chk(cap_val == v, "R11 value with dma off", 32'(cap_val), 32'(v));
      chk(irq == 1'b0, "R9 irq gated off", 32'(irq), 0);
    end
    repeat (4) @(posedge clk);
    chk(exp_q.size() == 0, "R10 all captures signalled", exp_q.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule